// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block records a stream of ready-made 32-bit trace frames into an on-chip RAM used as a ring. Each frame offered with its valid strobe while capture is enabled is staged for one cycle and then written at the write pointer, which then advances and wraps. Once the pointer has wrapped, the oldest valid frame sits at the write pointer. Until then the number of valid frames equals the write pointer.

An external trigger input arms a post-trigger countdown held in a software-loaded counter. From the trigger cycle on, each accepted frame decrements the counter. When it runs out, capture stops by itself and a completion flag is raised. Software reads the captured trace back through a data register that auto-advances a read pointer.

All access goes through a small synchronous register port of nine 32-bit words. A read issued in one cycle returns its data in the next. The RAM depth is a parameter and must be a power of two.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, capture is disabled, both pointers and the countdown read 0, and the status word reads 0x8 (only the drained flag set).
- R2: Word address 0 returns the ID_VALUE parameter, address 1 returns DEPTH and address 2 returns 32. These three are read-only, and writes to them have no effect. Addresses 9 to 15 read as 0.
- R3: While control bit 0 (address 8) is 1, every cycle with frm_valid high stores frm_data at the write pointer (address 6). The pointer then increments modulo DEPTH.
- R4: Status bit 0 (address 3) is set when a frame is stored at the last RAM address. It stays set until capture is re-enabled.
- R5: A trig_in pulse while capture is enabled sets status bit 1, which stays set. A pulse while capture is disabled is ignored.
- R6: After a trigger with countdown N >= 1 (address 7), exactly N frames are accepted, counting from the trigger cycle. Capture then stops: control bit 0 clears, status bit 2 sets and the countdown reads 0. With N = 0, capture stops in the trigger cycle, and at most that cycle's frame is kept.
- R7: Status bit 3 is low in the cycle after a frame is accepted, while that frame is pending for the RAM, and high otherwise.
- R8: Reading address 4 returns the RAM entry at the read pointer (address 5) and then increments that pointer. Reads of any other address leave the pointer unchanged.
- R9: Both pointers are writable, using the low address bits of the write data. The read pointer wraps from DEPTH-1 to 0.
- R10: Writing control bit 0 as 0 stops capture, and frames offered afterwards are not stored.
- R11: Writing control bit 0 as 1 while capture is disabled clears status bits 0, 1 and 2. Control bit 1 (port-mode select) is stored and read back unchanged, including when capture stops by itself.
- R12: Read data for a request made in cycle t appears on bus_rdata during cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame strobe |
| frm_data | input | 32 | Trace frame |
| trig_in | input | 1 | Trigger event |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |

## Verification
The assertions check, on every cycle, that the full and triggered flags only change when they are allowed to, that the write pointer steps by one per stored frame, that nothing is staged while capture is off, that capture is already off when completion rises, and that the read pointer moves only on a data-register read. How many frames the countdown admits, what the RAM holds after a wrap, the readback of each register and the clearing of the flags on re-enable can only be shown by the bench's scenarios. The same holds for the one-cycle window in which the drained flag drops.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [3:0] {
    A_ID    = 4'd0,
    A_DEPTH = 4'd1,
    A_WIDTH = 4'd2,
    A_STAT  = 4'd3,
    A_DATA  = 4'd4,
    A_RPTR  = 4'd5,
    A_WPTR  = 4'd6,
    A_TCNT  = 4'd7,
    A_CTRL  = 4'd8
  } tr_addr_e;

  localparam int FRAME_W = 32;
endpackage

// File: rtl/tr_ram.sv
module tr_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tr_acq.sv
module tr_acq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frm_valid,
  input  logic [31:0]   frm_data,
  input  logic          trig_in,
  input  logic          wr_ctrl,
  input  logic          wr_wptr,
  input  logic          wr_tcnt,
  input  logic [31:0]   wdata,
  output logic          en_q,
  output logic          demux_q,
  output logic          full_q,
  output logic          trig_q,
  output logic          acq_q,
  output logic          stage_v,
  output logic [31:0]   stage_d,
  output logic [AW-1:0] wptr_q,
  output logic [31:0]   tcnt_q
);
  logic trig_act;
  logic stop;

  assign trig_act = trig_q | trig_in;
  // countdown ends on the trigger itself (N=0) or on the last admitted frame
  assign stop = en_q && trig_act &&
                ((tcnt_q == 32'd0) || (frm_valid && tcnt_q == 32'd1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      demux_q <= 1'b0;
      full_q  <= 1'b0;
      trig_q  <= 1'b0;
      acq_q   <= 1'b0;
      stage_v <= 1'b0;
      stage_d <= '0;
      wptr_q  <= '0;
      tcnt_q  <= '0;
    end else begin
      stage_v <= en_q && frm_valid;
      stage_d <= frm_data;
      if (stage_v) begin
        wptr_q <= wptr_q + 1'b1;
        if (&wptr_q) full_q <= 1'b1;
      end
      if (en_q && trig_act) begin
        trig_q <= 1'b1;
        if (frm_valid && tcnt_q != 32'd0) tcnt_q <= tcnt_q - 32'd1;
      end
      if (stop) begin
        en_q  <= 1'b0;
        acq_q <= 1'b1;
      end
      // register-port writes take precedence over the capture logic
      if (wr_ctrl) begin
        en_q    <= wdata[0];
        demux_q <= wdata[1];
        if (wdata[0] && !en_q) begin
          full_q <= 1'b0;
          trig_q <= 1'b0;
          acq_q  <= 1'b0;
        end
      end
      if (wr_wptr) wptr_q <= wdata[AW-1:0];
      if (wr_tcnt) tcnt_q <= wdata;
    end
  end

  // R4: full never drops except through a re-enable
  a_r4_full_sticky: assert property (@(posedge clk) disable iff (rst)
    full_q && !(wr_ctrl && wdata[0] && !en_q) |=> full_q);
  // R5: triggered can only rise while capture was on
  a_r5_trig_needs_en: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_q) |-> $past(en_q));
  // R3: one pointer step per stored frame
  a_r3_wptr_step: assert property (@(posedge clk) disable iff (rst)
    stage_v && !wr_wptr |=> wptr_q == AW'($past(wptr_q) + 1'b1));
  // R10: nothing is staged while capture is off
  a_r10_idle_no_stage: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !stage_v);
  // R6: completion coincides with capture being off
  a_r6_done_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_q) |-> !en_q);
endmodule

// File: rtl/tr_regfile.sv
module tr_regfile
  import tr_pkg::*;
#(
  parameter int          DEPTH    = 256,
  parameter logic [31:0] ID_VALUE = 32'h0,
  localparam int         AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [3:0]    bus_addr,
  input  logic [AW-1:0] wdata_lo,
  input  logic          en,
  input  logic          demux,
  input  logic          full,
  input  logic          trig,
  input  logic          acq,
  input  logic          pend,
  input  logic [AW-1:0] wptr,
  input  logic [31:0]   tcnt,
  input  logic [31:0]   ram_q,
  output logic          wr_ctrl,
  output logic          wr_wptr,
  output logic          wr_tcnt,
  output logic [AW-1:0] rptr_q,
  output logic [31:0]   bus_rdata
);
  logic        rd;
  logic        rd_data;
  logic        from_ram_q;
  logic [31:0] reg_q;
  logic [31:0] rd_mux;

  assign rd      = bus_sel && !bus_wr;
  assign rd_data = rd && (bus_addr == A_DATA);
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_wptr = bus_sel && bus_wr && (bus_addr == A_WPTR);
  assign wr_tcnt = bus_sel && bus_wr && (bus_addr == A_TCNT);

  always_comb begin
    case (bus_addr)
      A_ID:    rd_mux = ID_VALUE;
      A_DEPTH: rd_mux = 32'(DEPTH);
      A_WIDTH: rd_mux = 32'(FRAME_W);
      A_STAT:  rd_mux = {28'd0, !pend, acq, trig, full};
      A_RPTR:  rd_mux = 32'(rptr_q);
      A_WPTR:  rd_mux = 32'(wptr);
      A_TCNT:  rd_mux = tcnt;
      A_CTRL:  rd_mux = {30'd0, demux, en};
      default: rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q     <= '0;
      reg_q      <= '0;
      from_ram_q <= 1'b0;
    end else begin
      from_ram_q <= rd_data;
      if (rd) reg_q <= rd_mux;
      if (bus_sel && bus_wr && bus_addr == A_RPTR) rptr_q <= wdata_lo;
      else if (rd_data) rptr_q <= rptr_q + 1'b1;
    end
  end

  // RAM output register or read-mux register, both one cycle behind the request
  assign bus_rdata = from_ram_q ? ram_q : reg_q;

  // R8: a data read advances the read pointer by one
  a_r8_rptr_step: assert property (@(posedge clk) disable iff (rst)
    rd_data |=> rptr_q == AW'($past(rptr_q) + 1'b1));
  // R8: other accesses leave it alone
  a_r8_rptr_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && (bus_addr == A_DATA || bus_addr == A_RPTR)) |=> $stable(rptr_q));
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf #(
  parameter int          DEPTH    = 256,
  parameter logic [31:0] ID_VALUE = 32'h7B00_0001,
  localparam int         AW       = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        frm_valid,
  input  logic [31:0] frm_data,
  input  logic        trig_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic          en, demux, full, trig, acq, stage_v;
  logic [31:0]   stage_d, tcnt, ram_q;
  logic [AW-1:0] wptr, rptr;
  logic          wr_ctrl, wr_wptr, wr_tcnt;

  tr_acq #(.AW(AW)) u_acq (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .trig_in(trig_in), .wr_ctrl(wr_ctrl), .wr_wptr(wr_wptr), .wr_tcnt(wr_tcnt),
    .wdata(bus_wdata), .en_q(en), .demux_q(demux), .full_q(full), .trig_q(trig),
    .acq_q(acq), .stage_v(stage_v), .stage_d(stage_d), .wptr_q(wptr), .tcnt_q(tcnt)
  );

  tr_ram #(.DEPTH(DEPTH), .DW(32)) u_ram (
    .clk(clk), .we(stage_v), .waddr(wptr), .wdata(stage_d),
    .raddr(rptr), .rdata(ram_q)
  );

  tr_regfile #(.DEPTH(DEPTH), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wdata_lo(bus_wdata[AW-1:0]), .en(en), .demux(demux), .full(full), .trig(trig),
    .acq(acq), .pend(stage_v), .wptr(wptr), .tcnt(tcnt), .ram_q(ram_q),
    .wr_ctrl(wr_ctrl), .wr_wptr(wr_wptr), .wr_tcnt(wr_tcnt), .rptr_q(rptr),
    .bus_rdata(bus_rdata)
  );

  initial a_depth_pow2: assert (DEPTH == (1 << AW));
endmodule

// File: tb/sim_trace_ring_buf.sv
module sim_trace_ring_buf;
  localparam int          DEPTH = 16;
  localparam logic [31:0] IDV   = 32'h5A17_0C02;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_valid = 1'b0;
  logic [31:0] frm_data = '0;
  logic        trig_in = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  logic [31:0] v;

  always #10 clk = ~clk;

  trace_ring_buf #(.DEPTH(DEPTH), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_data(frm_data),
    .trig_in(trig_in), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {address, expected value} right after reset (R1, R2)
  localparam logic [35:0] RST_TAB [10] = '{
    {4'd0, IDV}, {4'd1, 32'd16}, {4'd2, 32'd32}, {4'd3, 32'h8},
    {4'd5, 32'd0}, {4'd6, 32'd0}, {4'd7, 32'd0}, {4'd8, 32'd0},
    {4'd9, 32'd0}, {4'd15, 32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // R12: data sampled one cycle after the request
  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic push(input int n, input logic [31:0] base, input int trig_at);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_valid = 1'b1; frm_data = base + 32'(i); trig_in = (i == trig_at);
    end
    @(negedge clk);
    frm_valid = 1'b0; trig_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      rd(RST_TAB[i][35:32], v);
      chk($sformatf("R1/R2 reset addr %0d", RST_TAB[i][35:32]), v, RST_TAB[i][31:0]);
    end

    // R3: plain capture
    wr(4'd8, 32'h1);
    push(5, 32'hA000_0000, -1);
    rd(4'd6, v); chk("R3 wptr after 5 frames", v, 32'd5);
    rd(4'd3, v); chk("R4 no full before wrap", v, 32'h8);
    rd(4'd8, v); chk("R11 ctrl readback", v, 32'h1);

    // R8: readback with auto-increment
    wr(4'd5, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(4'd4, v); chk($sformatf("R8 ram data %0d", i), v, 32'hA000_0000 + 32'(i));
    end
    rd(4'd5, v); chk("R8 rptr advanced", v, 32'd5);
    rd(4'd3, v);
    rd(4'd5, v); chk("R8 rptr held by other reads", v, 32'd5);

    // R7: drained flag drops while a frame is pending
    @(negedge clk); frm_valid = 1'b1; frm_data = 32'hC0DE_0001;
    @(negedge clk); frm_valid = 1'b0; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd3;
    @(negedge clk); bus_sel = 1'b0;
    chk("R7 pending frame", bus_rdata, 32'h0);
    rd(4'd3, v); chk("R7 drained again", v, 32'h8);

    // R4: wrap sets full, pointer wraps to 0
    push(10, 32'hB000_0000, -1);
    rd(4'd3, v); chk("R4 full after wrap", v, 32'h9);
    rd(4'd6, v); chk("R3 wptr wrapped", v, 32'd0);

    // R10: stop by write
    wr(4'd8, 32'h0);
    push(3, 32'hD000_0000, -1);
    rd(4'd6, v); chk("R10 no store while stopped", v, 32'd0);
    rd(4'd8, v); chk("R10 ctrl reads stopped", v, 32'd0);

    // R5: trigger ignored while stopped
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    rd(4'd3, v); chk("R5 trigger ignored when off", v, 32'h9);

    // R11: re-enable clears sticky flags, mode bit kept
    wr(4'd7, 32'd3);
    wr(4'd6, 32'd0);
    wr(4'd8, 32'h3);
    rd(4'd3, v); chk("R11 flags cleared", v, 32'h8);
    rd(4'd8, v); chk("R11 ctrl with mode bit", v, 32'h3);

    // R6: countdown of 3 admits 3 frames from the trigger cycle on
    push(2, 32'hE000_0000, -1);
    push(6, 32'hE100_0000, 0);
    rd(4'd6, v); chk("R6 frames admitted", v, 32'd5);
    rd(4'd3, v); chk("R6 R5 trig+done status", v, 32'hE);
    rd(4'd8, v); chk("R6 enable cleared, mode kept", v, 32'h2);
    rd(4'd7, v); chk("R6 countdown empty", v, 32'd0);
    wr(4'd5, 32'd4);
    rd(4'd4, v); chk("R6 last admitted frame", v, 32'hE100_0002);

    // R6: zero countdown stops at the trigger cycle
    wr(4'd6, 32'd0);
    wr(4'd8, 32'h1);
    push(4, 32'hF000_0000, 0);
    rd(4'd6, v); chk("R6 zero count keeps one frame", v, 32'd1);
    rd(4'd3, v); chk("R6 zero count status", v, 32'hE);

    // R2: read-only id
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); chk("R2 id not writable", v, IDV);

    // R9: read pointer wrap
    wr(4'd5, 32'd15);
    rd(4'd4, v); chk("R9 entry at last address", v, 32'hB000_0009);
    rd(4'd4, v); chk("R9 entry after wrap", v, 32'hF000_0000);
    rd(4'd5, v); chk("R9 rptr wrapped", v, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule